// File: doc/BRIEF.md
# Byte-Loaded Multiply/Divide Accelerator

This block is an arithmetic unit that a narrow processor bus drives one byte at a time. It offers a 16x16 unsigned multiply, a 32/16 unsigned divide and a 16/16 unsigned divide. There is no opcode. The unit works out which operation is wanted from the order and the number of byte writes made to its two registers, the A register and the B register. The last operand byte starts an iterative engine. A busy flag stays high for a fixed number of machine cycles, and each operation has its own count.

Software writes the operands and polls the busy flag until it clears. It then reads the result, most significant byte first, from the A register. After a divide, the remainder comes from the B register, also most significant byte first. A machine-cycle enable input paces the engine, so the busy time is counted in enabled cycles and not in clocks.

Top module: `ma_accel`

## Requirements
- R1: After reset, busy_o and dz_err_o are 0, and a read of either register (sel_i=0 selects A, sel_i=1 selects B) returns 8'h00.
- R2: Write B twice (multiplier low byte, then high byte) and then A twice (multiplicand low byte, then high byte). The second A write starts a multiply. Four A reads then return the 32-bit product, most significant byte first.
- R3: A divide begins with a first write to A. Four A writes (dividend bytes, least significant first) followed by two B writes (divisor low byte, then high byte) start a 32/16 divide. Four A reads then return the 32-bit quotient, MSB first.
- R4: Two A writes followed by two B writes start a 16/16 divide. Two A reads then return the 16-bit quotient, MSB first.
- R5: After either divide, two B reads return the 16-bit remainder, MSB first.
- R6: busy_o rises on the clock edge that accepts the starting write. It then stays high for exactly 6 enabled cycles (cyc_en_i=1) for a multiply and 9 for either divide.
- R7: Writes made while busy_o is high are ignored. They change neither the running operation nor the operand sequence that follows.
- R8: Reads made while busy_o is high return 8'h00 and do not advance the read position.
- R9: A divide by a zero divisor returns an all-ones quotient of the operation's width and a zero remainder. It also sets dz_err_o, which then stays at 1 until reset.
- R10: The first write of a new operand sequence returns both read positions to the most significant byte. Reads past the last valid byte return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_en_i | input | 1 | Machine-cycle enable that paces the engine |
| wr_i | input | 1 | Byte write strobe |
| rd_i | input | 1 | Byte read strobe |
| sel_i | input | 1 | Register select: 0 = A, 1 = B |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle rd_i is high |
| busy_o | output | 1 | Engine running |
| dz_err_o | output | 1 | Sticky divide-by-zero flag |

## Verification
The hardest situation to reach from the ports is bus traffic that arrives while the engine is still running. A stray B write in that window could quietly open a new multiply sequence, and a read there could move the result pointer. The bench makes these accesses right after the starting write. It then runs a full divide load, so a sequence that was opened by mistake would corrupt the next result. Busy time is measured with the cycle enable both held high and strobed one cycle in three, so that counting clocks instead of enabled cycles shows up as a wrong result.

// File: rtl/ma_pkg.sv
package ma_pkg;
  typedef enum logic [1:0] {OP_MUL, OP_DIV32, OP_DIV16} op_e;
  typedef enum logic [2:0] {S_IDLE, S_MUL_B, S_MUL_A, S_DIV_A, S_DIV_B} seq_e;
endpackage

// File: rtl/ma_seq.sv
module ma_seq
  import ma_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            sel_i,
  input  logic [7:0]      wdata_i,
  input  logic            busy_i,
  output logic            begin_o,
  output logic            start_o,
  output op_e             op_o,
  output logic [2*HW-1:0] opa_o,
  output logic [HW-1:0]   opb_o
);
  localparam int NB_H = HW / 8;
  localparam int NB_F = 2 * NB_H;
  localparam int CW   = $clog2(NB_F + 1);
  localparam logic [CW-1:0] NB_H_C = CW'(NB_H);
  localparam logic [CW-1:0] NB_F_C = CW'(NB_F);
  localparam logic [CW-1:0] LAST_H = CW'(NB_H - 1);

  seq_e st_q, st_d;
  logic [CW-1:0] na_q, na_d, nb_q, nb_d;
  logic [2*HW-1:0] opa_q, opa_d;
  logic [HW-1:0] opb_q, opb_d;
  logic we;

  assign we = wr_i && !busy_i;

  always_comb begin
    st_d = st_q; na_d = na_q; nb_d = nb_q;
    opa_d = opa_q; opb_d = opb_q;
    begin_o = 1'b0; start_o = 1'b0; op_o = OP_MUL;
    unique case (st_q)
      S_IDLE: if (we) begin
        begin_o = 1'b1;
        opa_d = '0; opb_d = '0;
        if (!sel_i) begin
          opa_d[7:0] = wdata_i; na_d = CW'(1); nb_d = '0; st_d = S_DIV_A;
        end else begin
          opb_d[7:0] = wdata_i; nb_d = CW'(1); na_d = '0; st_d = S_MUL_B;
        end
      end
      S_MUL_B: if (we) begin
        if (sel_i) begin
          if (nb_q < NB_H_C) begin
            opb_d[int'(nb_q)*8 +: 8] = wdata_i; nb_d = nb_q + 1'b1;
          end
        end else begin
          opa_d[7:0] = wdata_i; na_d = CW'(1); st_d = S_MUL_A;
        end
      end
      S_MUL_A: if (we && !sel_i) begin
        opa_d[int'(na_q)*8 +: 8] = wdata_i;
        na_d = na_q + 1'b1;
        if (na_q == LAST_H) begin
          start_o = 1'b1; op_o = OP_MUL; st_d = S_IDLE;
        end
      end
      S_DIV_A: if (we) begin
        if (!sel_i) begin
          if (na_q < NB_F_C) begin
            opa_d[int'(na_q)*8 +: 8] = wdata_i; na_d = na_q + 1'b1;
          end
        end else begin
          opb_d[7:0] = wdata_i; nb_d = CW'(1); st_d = S_DIV_B;
        end
      end
      S_DIV_B: if (we && sel_i) begin
        opb_d[int'(nb_q)*8 +: 8] = wdata_i;
        nb_d = nb_q + 1'b1;
        if (nb_q == LAST_H) begin
          start_o = 1'b1;
          op_o = (na_q == NB_F_C) ? OP_DIV32 : OP_DIV16;
          st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; na_q <= '0; nb_q <= '0; opa_q <= '0; opb_q <= '0;
    end else begin
      st_q <= st_d; na_q <= na_d; nb_q <= nb_d; opa_q <= opa_d; opb_q <= opb_d;
    end
  end

  assign opa_o = opa_d;
  assign opb_o = opb_d;
endmodule

// File: rtl/ma_eng.sv
module ma_eng
  import ma_pkg::*;
#(
  parameter int HW      = 16,
  parameter int MUL_CYC = 6,
  parameter int DIV_CYC = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cyc_en_i,
  input  logic            start_i,
  input  op_e             op_i,
  input  logic [2*HW-1:0] opa_i,
  input  logic [HW-1:0]   opb_i,
  output logic            busy_o,
  output op_e             op_o,
  output logic [2*HW-1:0] res_o,
  output logic [HW-1:0]   rem_o,
  output logic            dz_o
);
  localparam int FW    = 2 * HW;
  localparam int MSTEP = (HW + MUL_CYC - 1) / MUL_CYC;
  localparam int DSTEP = (FW + DIV_CYC - 1) / DIV_CYC;
  localparam int MAXC  = (MUL_CYC > DIV_CYC) ? MUL_CYC : DIV_CYC;
  localparam int CW    = $clog2(MAXC + 1);
  localparam int BW    = $clog2(FW + 1);
  localparam logic [CW-1:0] MUL_N = CW'(MUL_CYC);
  localparam logic [CW-1:0] DIV_N = CW'(DIV_CYC);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  op_e           op_q;
  logic [FW-1:0] acc_q, mc_q, quo_q;
  logic [HW-1:0] mp_q, dv_q;
  logic [HW:0]   rem_q;
  logic [BW-1:0] left_q;

  logic [FW-1:0] acc_s, mc_s, quo_s;
  logic [HW-1:0] mp_s;
  logic [HW:0]   rem_s, rsh;
  logic [BW-1:0] left_s;

  // shift-add, MSTEP multiplier bits per machine cycle
  always_comb begin
    acc_s = acc_q; mc_s = mc_q; mp_s = mp_q;
    for (int k = 0; k < MSTEP; k++) begin
      if (mp_s[0]) acc_s = acc_s + mc_s;
      mc_s = mc_s << 1;
      mp_s = mp_s >> 1;
    end
  end

  // restoring divide, DSTEP quotient bits per machine cycle
  always_comb begin
    rem_s = rem_q; quo_s = quo_q; left_s = left_q; rsh = '0;
    for (int k = 0; k < DSTEP; k++) begin
      if (left_s != '0) begin
        rsh = {rem_s[HW-1:0], quo_s[FW-1]};
        quo_s = quo_s << 1;
        if (rsh >= {1'b0, dv_q}) begin
          rem_s = rsh - {1'b0, dv_q};
          quo_s[0] = 1'b1;
        end else begin
          rem_s = rsh;
        end
        left_s = left_s - 1'b1;
      end
    end
  end

  assign dz_o = start_i && (op_i != OP_MUL) && (opb_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; cnt_q <= '0; op_q <= OP_MUL;
      acc_q <= '0; mc_q <= '0; mp_q <= '0;
      quo_q <= '0; rem_q <= '0; dv_q <= '0; left_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      op_q   <= op_i;
      if (op_i == OP_MUL) begin
        cnt_q <= MUL_N;
        acc_q <= '0;
        mc_q  <= {{HW{1'b0}}, opa_i[HW-1:0]};
        mp_q  <= opb_i;
      end else begin
        cnt_q <= DIV_N;
        dv_q  <= opb_i;
        rem_q <= '0;
        if (opb_i == '0) begin
          quo_q  <= (op_i == OP_DIV32) ? {FW{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};
          left_q <= '0;
        end else if (op_i == OP_DIV32) begin
          quo_q  <= opa_i;
          left_q <= BW'(FW);
        end else begin
          quo_q  <= {opa_i[HW-1:0], {HW{1'b0}}};
          left_q <= BW'(HW);
        end
      end
    end else if (busy_q && cyc_en_i) begin
      cnt_q  <= cnt_q - 1'b1;
      busy_q <= (cnt_q != CW'(1));
      if (op_q == OP_MUL) begin
        acc_q <= acc_s; mc_q <= mc_s; mp_q <= mp_s;
      end else begin
        quo_q <= quo_s; rem_q <= rem_s; left_q <= left_s;
      end
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
  assign res_o  = (op_q == OP_MUL) ? acc_q : quo_q;
  assign rem_o  = rem_q[HW-1:0];
endmodule

// File: rtl/ma_rd.sv
module ma_rd
  import ma_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            begin_i,
  input  logic            rd_i,
  input  logic            sel_i,
  input  logic            busy_i,
  input  op_e             op_i,
  input  logic [2*HW-1:0] res_i,
  input  logic [HW-1:0]   rem_i,
  output logic [7:0]      rdata_o
);
  localparam int NB_H = HW / 8;
  localparam int NB_F = 2 * NB_H;
  localparam int PW   = $clog2(NB_F + 1);

  logic [PW-1:0] pa_q, pb_q;
  logic [7:0] a_byte, b_byte;
  logic rd_ok;
  int avail;

  assign rd_ok = rd_i && !busy_i;

  always_comb begin
    avail  = (op_i == OP_DIV16) ? NB_H : NB_F;
    a_byte = 8'h00;
    b_byte = 8'h00;
    if (int'(pa_q) < avail) a_byte = res_i[(avail - 1 - int'(pa_q))*8 +: 8];
    if (op_i != OP_MUL && int'(pb_q) < NB_H) b_byte = rem_i[(NB_H - 1 - int'(pb_q))*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q <= '0; pb_q <= '0;
    end else if (begin_i) begin
      pa_q <= '0; pb_q <= '0;
    end else if (rd_ok) begin
      if (sel_i) begin
        if (pb_q != PW'(NB_F)) pb_q <= pb_q + 1'b1;
      end else begin
        if (pa_q != PW'(NB_F)) pa_q <= pa_q + 1'b1;
      end
    end
  end

  assign rdata_o = rd_ok ? (sel_i ? b_byte : a_byte) : 8'h00;
endmodule

// File: rtl/ma_accel.sv
module ma_accel
  import ma_pkg::*;
#(
  parameter int HW      = 16,
  parameter int MUL_CYC = 6,
  parameter int DIV_CYC = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cyc_en_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       sel_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       busy_o,
  output logic       dz_err_o
);
  logic            seq_begin, seq_start, dz;
  op_e             seq_op, eng_op;
  logic [2*HW-1:0] opa, res;
  logic [HW-1:0]   opb, rem;
  logic            busy, err_q;

  ma_seq #(.HW(HW)) u_seq (
    .clk_i, .rst_ni, .wr_i, .sel_i, .wdata_i,
    .busy_i(busy), .begin_o(seq_begin), .start_o(seq_start),
    .op_o(seq_op), .opa_o(opa), .opb_o(opb)
  );

  ma_eng #(.HW(HW), .MUL_CYC(MUL_CYC), .DIV_CYC(DIV_CYC)) u_eng (
    .clk_i, .rst_ni, .cyc_en_i, .start_i(seq_start), .op_i(seq_op),
    .opa_i(opa), .opb_i(opb), .busy_o(busy), .op_o(eng_op),
    .res_o(res), .rem_o(rem), .dz_o(dz)
  );

  ma_rd #(.HW(HW)) u_rd (
    .clk_i, .rst_ni, .begin_i(seq_begin), .rd_i, .sel_i,
    .busy_i(busy), .op_i(eng_op), .res_i(res), .rem_i(rem), .rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (dz) err_q <= 1'b1;
  end

  assign busy_o   = busy;
  assign dz_err_o = err_q;
endmodule

// File: rtl/ma_accel_chk.sv
module ma_accel_chk #(
  parameter int MUL_CYC = 6,
  parameter int DIV_CYC = 9
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cyc_en_i,
  input logic wr_i,
  input logic busy_o,
  input logic dz_err_o
);
  localparam int MAXC = (MUL_CYC > DIV_CYC) ? MUL_CYC : DIV_CYC;
  localparam int EW   = $clog2(MAXC + 2) + 1;

  logic [EW-1:0] en_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_cnt <= '0;
    else if (!busy_o) en_cnt <= '0;
    else if (cyc_en_i) en_cnt <= en_cnt + 1'b1;
  end

  p_start_by_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_i));

  p_end_on_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(cyc_en_i));

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (en_cnt == EW'(MUL_CYC) || en_cnt == EW'(DIV_CYC)));

  p_busy_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (en_cnt < EW'(MAXC)));

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dz_err_o) |-> dz_err_o);

  p_err_at_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dz_err_o) |-> $rose(busy_o));
endmodule

bind ma_accel ma_accel_chk #(.MUL_CYC(MUL_CYC), .DIV_CYC(DIV_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cyc_en_i(cyc_en_i),
  .wr_i(wr_i), .busy_o(busy_o), .dz_err_o(dz_err_o)
);

// File: tb/ma_accel_test.sv
module ma_accel_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cyc_en_i = 1'b1;
  logic wr_i = 1'b0, rd_i = 1'b0, sel_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic busy_o, dz_err_o;

  int total = 0, bad = 0;
  int en_period = 1, en_ph = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  ma_accel uut (
    .clk_i(clk), .rst_ni, .cyc_en_i, .wr_i, .rd_i, .sel_i,
    .wdata_i, .rdata_o, .busy_o, .dz_err_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    en_ph = (en_ph + 1) % en_period;
    cyc_en_i = (en_ph == 0);
  end

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each read against the scoreboard queue
  always @(negedge clk) begin
    if (rd_i) begin
      if (exp_q.size() == 0) check("scoreboard-empty", 1, 0);
      else check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    end
  end

  task automatic wr(bit s, logic [7:0] d);
    @(posedge clk); #1; wr_i = 1; sel_i = s; wdata_i = d;
    @(posedge clk); #1; wr_i = 0;
  endtask

  task automatic rd(bit s, logic [7:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1; rd_i = 1; sel_i = s;
    @(posedge clk); #1; rd_i = 0;
  endtask

  task automatic wait_done(int n, string tag);
    int c = 0;
    @(negedge clk);
    check({tag, " busy set"}, busy_o, 1);
    while (busy_o) begin
      if (cyc_en_i) c++;
      @(negedge clk);
    end
    check({tag, " busy length"}, c, n);
  endtask

  task automatic load_mul(logic [15:0] a, logic [15:0] b);
    wr(1, b[7:0]); wr(1, b[15:8]); wr(0, a[7:0]); wr(0, a[15:8]);
  endtask

  task automatic read_word(logic [31:0] v, int nbytes, bit s, string tag);
    for (int i = nbytes - 1; i >= 0; i--) rd(s, v[i*8 +: 8], tag);
  endtask

  task automatic do_mul(logic [15:0] a, logic [15:0] b);
    logic [31:0] p = 32'(a) * 32'(b);
    load_mul(a, b);
    wait_done(6, "R6 mul");
    read_word(p, 4, 0, "R2 product");
  endtask

  task automatic do_div32(logic [31:0] n, logic [15:0] d);
    logic [31:0] q = (d == 0) ? 32'hFFFF_FFFF : n / 32'(d);
    logic [15:0] r = (d == 0) ? 16'h0 : 16'(n % 32'(d));
    for (int i = 0; i < 4; i++) wr(0, n[i*8 +: 8]);
    wr(1, d[7:0]); wr(1, d[15:8]);
    wait_done(9, "R6 div32");
    read_word(q, 4, 0, (d == 0) ? "R9 quotient32" : "R3 quotient");
    read_word({16'h0, r}, 2, 1, (d == 0) ? "R9 remainder" : "R5 remainder32");
  endtask

  task automatic do_div16(logic [15:0] n, logic [15:0] d);
    logic [15:0] q = (d == 0) ? 16'hFFFF : n / d;
    logic [15:0] r = (d == 0) ? 16'h0 : n % d;
    wr(0, n[7:0]); wr(0, n[15:8]); wr(1, d[7:0]); wr(1, d[15:8]);
    wait_done(9, "R6 div16");
    read_word({16'h0, q}, 2, 0, (d == 0) ? "R9 quotient16" : "R4 quotient");
    read_word({16'h0, r}, 2, 1, (d == 0) ? "R9 remainder16" : "R5 remainder16");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      check("watchdog", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy_o, 0);
    check("R1 err", dz_err_o, 0);
    rd(0, 8'h00, "R1 A read");
    rd(1, 8'h00, "R1 B read");

    do_mul(16'hFFFF, 16'hFFFF);
    do_mul(16'h1234, 16'h00AB);
    do_div32(32'hDEAD_BEEF, 16'h0123);
    do_div16(16'hFFFE, 16'h0007);
    do_div16(16'h0005, 16'h0009);

    // R10: partial read, new sequence restarts at MSB, over-read returns 0
    load_mul(16'h0102, 16'h0304);
    wait_done(6, "R6 mul");
    p = 32'h0102 * 32'h0304;
    rd(0, p[31:24], "R10 first"); rd(0, p[23:16], "R10 second");
    do_mul(16'h8001, 16'h7FFF);
    rd(0, 8'h00, "R10 past end");
    do_div16(16'h1000, 16'h0003);
    rd(0, 8'h00, "R10 past end div16");
    rd(1, 8'h00, "R10 past end rem");

    // R7 and R8: accesses during busy
    load_mul(16'hABCD, 16'h1357);
    wr(0, 8'h55);
    wr(1, 8'hAA);
    @(posedge clk); #1; exp_q.push_back(8'h00); tag_q.push_back("R8 read while busy");
    rd_i = 1; sel_i = 0;
    @(posedge clk); #1; rd_i = 0;
    while (busy_o) @(negedge clk);
    p = 32'hABCD * 32'h1357;
    read_word(p, 4, 0, "R7 R8 product intact");
    do_div16(16'h4321, 16'h0010);

    // slow machine cycles
    en_period = 3;
    do_mul(16'h00FF, 16'h0101);
    do_div32(32'h0001_0000, 16'h0002);
    en_period = 1;

    // random operands vs model
    for (int i = 0; i < 8; i++) begin
      do_mul(16'($urandom), 16'($urandom));
      do_div32($urandom, 16'($urandom_range(1, 65535)));
      do_div16(16'($urandom), 16'($urandom_range(1, 300)));
    end

    // R9 divide by zero, sticky flag
    check("R9 err before", dz_err_o, 0);
    do_div32(32'h1234_5678, 16'h0000);
    check("R9 err set", dz_err_o, 1);
    do_div16(16'h00FF, 16'h0000);
    do_mul(16'h0011, 16'h0022);
    check("R9 err sticky", dz_err_o, 1);

    repeat (4) @(posedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule